// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns level changes on four external pins into interrupt requests for a processor core. Each pin has its own configuration: a 2-bit edge mode that selects rising, falling, both, or no edges, an enable bit, and a sticky request flag. A selected edge sets the flag, and only software can clear it. The pins are grouped in pairs, and each pair drives one request line. The block also gives the vector address pair and a 2-bit priority level for each line.

Software reaches the configuration through a synchronous byte-wide port with an address, write data, a write strobe and registered read data. A control byte holds the fields of two pins. A separate byte holds the priority levels. While the device sits in its clock-halted stop state, a pin that is both flagged and enabled raises a wake output. Nothing else in the block can raise that wake output.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every flag, enable, edge mode and level reads as 0, and `irq_o`, `wake_o` and both vector outputs are 0.
- R2: Edge mode encoding per pin is 00 = off, 01 = rising, 10 = falling, 11 = both. A pin change that matches the mode sets the pin's flag within four clock cycles. A change that does not match leaves the flag at 0.
- R3: A flag stays at 1 until software writes 0 to its flag bit. Writing 1 to a flag bit does not set the flag. If an edge and a clearing write hit the same flag in the same cycle, the flag stays at 1.
- R4: `irq_o[k]` is 1 one cycle after either pin 2k or pin 2k+1 has both its flag and its enable at 1. It returns to 0 one cycle after neither pin is in that state. A flag with its enable at 0 raises nothing.
- R5: Writing the enable bit to 1 while the flag is already 1 raises the request line in the cycle after the write.
- R6: A single write that sets the enable bit and clears the flag leaves the request line and `wake_o` at 0.
- R7: `wake_o` is 1 one cycle after `stop_mode_i` is 1 while any pin is flagged and enabled. `wake_o` is 0 whenever `stop_mode_i` was 0 in the previous cycle.
- R8: Control byte 0x0070 holds pins 0 and 1, and control byte 0x0071 holds pins 2 and 3. Within a control byte, the lower-numbered pin sits in bits [3:0] and the other pin in bits [7:4]. Each nibble is laid out as {flag, enable, mode[1:0]}. `bus_rdata_o` shows the addressed byte one cycle after the address is presented. Writes to an unmapped address change nothing.
- R9: Byte 0x007B holds the level of line 0 in bits [1:0] and the level of line 1 in bits [3:2]. Its upper bits read as 0. `irq_level_o` follows the stored bits from the cycle after the write.
- R10: The vector outputs depend on which lines are active:
  - Line 0 active: `vec_hi_addr_o` = 0xFFFA and `vec_lo_addr_o` = 0xFFFB. This holds even when line 1 is also active.
  - Only line 1 active: the outputs are 0xFFF8 and 0xFFF9.
  - No line active: both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_i | input | 4 | Asynchronous external interrupt pins |
| stop_mode_i | input | 1 | High while the device is in stop mode |
| bus_addr_i | input | 16 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 2 | Request lines to the core, one per pin pair |
| wake_o | output | 1 | Stop-mode release request |
| irq_level_o | output | 4 | Priority levels, line 0 in [1:0] |
| vec_hi_addr_o | output | 16 | Upper-byte vector address of the active line |
| vec_lo_addr_o | output | 16 | Lower-byte vector address of the active line |

## Verification
The pins are driven with single rising and single falling transitions under each edge mode. This shows that the mode decoding separates the two directions and that mode 00 ignores both. Flag-set-then-enable and enable-with-clear writes show the difference between a pending request that fires at once and one that is discarded. An edge placed in the same cycle as a clearing write shows that the edge takes precedence. Activating one line and then both lines tells the two vector pairs apart and shows that line 0 wins.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  localparam int          VEC_W        = 16;
  localparam logic [15:0] VEC_HI_LINE0 = 16'hFFFA;

  // Each further line sits two bytes below the previous one.
  function automatic logic [VEC_W-1:0] vec_hi_addr(input int line);
    return VEC_HI_LINE0 - VEC_W'(2 * line);
  endfunction

  function automatic logic [VEC_W-1:0] vec_lo_addr(input int line);
    return vec_hi_addr(line) + VEC_W'(1);
  endfunction

endpackage

// File: rtl/eirq_edge_detect.sv
module eirq_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pin_i,
  input  eirq_pkg::edge_mode_e  mode_i,
  output logic                  hit_o
);
  import eirq_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;
  logic                   rise;
  logic                   fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    cur  = sync_q[SYNC_STAGES-1];
    rise = cur & ~prev_q;
    fall = ~cur & prev_q;
    case (mode_i)
      EDGE_OFF:  hit_o = 1'b0;
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      default:   hit_o = rise | fall;
    endcase
  end

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs #(
  parameter int N_PINS        = 4,
  parameter int PINS_PER_LINE = 2,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int CTRL_BASE     = 'h0070,
  parameter int LEVEL_ADDR    = 'h007B,
  parameter int LEVEL_W       = 2,
  localparam int N_LINES      = N_PINS / PINS_PER_LINE,
  localparam int LVL_BITS     = N_LINES * LEVEL_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   we_i,
  input  logic [N_PINS-1:0]      hit_i,
  output logic [N_PINS-1:0]      flag_o,
  output logic [N_PINS-1:0]      en_o,
  output logic [N_PINS-1:0][1:0] mode_o,
  output logic [LVL_BITS-1:0]    level_o,
  output logic [DATA_W-1:0]      rdata_o
);
  localparam int NIB          = 4;
  localparam int PINS_PER_REG = DATA_W / NIB;
  localparam int N_CTRL       = (N_PINS + PINS_PER_REG - 1) / PINS_PER_REG;

  logic [N_PINS-1:0]      flag_q;
  logic [N_PINS-1:0]      en_q;
  logic [N_PINS-1:0][1:0] mode_q;
  logic [LVL_BITS-1:0]    level_q;
  logic [DATA_W-1:0]      rdata_q;
  logic [DATA_W-1:0]      rd_next;
  logic [N_CTRL-1:0]      ctrl_sel;
  logic                   level_sel;

  always_comb begin
    for (int r = 0; r < N_CTRL; r++)
      ctrl_sel[r] = (addr_i == ADDR_W'(CTRL_BASE + r));
    level_sel = (addr_i == ADDR_W'(LEVEL_ADDR));
  end

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < N_PINS; p++)
      if (ctrl_sel[p / PINS_PER_REG])
        rd_next[NIB*(p % PINS_PER_REG) +: NIB] = {flag_q[p], en_q[p], mode_q[p]};
    if (level_sel)
      rd_next[LVL_BITS-1:0] = level_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= '0;
      en_q    <= '0;
      mode_q  <= '0;
      level_q <= '0;
      rdata_q <= '0;
    end else begin
      for (int p = 0; p < N_PINS; p++) begin
        if (we_i && ctrl_sel[p / PINS_PER_REG]) begin
          en_q[p]   <= wdata_i[NIB*(p % PINS_PER_REG) + 2];
          mode_q[p] <= wdata_i[NIB*(p % PINS_PER_REG) +: 2];
        end
        // Software can only clear; a fresh edge in the same cycle wins.
        flag_q[p] <= hit_i[p] |
                     (flag_q[p] & ~(we_i & ctrl_sel[p / PINS_PER_REG] &
                                    ~wdata_i[NIB*(p % PINS_PER_REG) + 3]));
      end
      if (we_i && level_sel)
        level_q <= wdata_i[LVL_BITS-1:0];
      rdata_q <= rd_next;
    end
  end

  assign flag_o  = flag_q;
  assign en_o    = en_q;
  assign mode_o  = mode_q;
  assign level_o = level_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int N_PINS        = 4,
  parameter int PINS_PER_LINE = 2,
  parameter int SYNC_STAGES   = 2,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int CTRL_BASE     = 'h0070,
  parameter int LEVEL_ADDR    = 'h007B,
  parameter int LEVEL_W       = 2,
  localparam int N_LINES      = N_PINS / PINS_PER_LINE,
  localparam int LVL_BITS     = N_LINES * LEVEL_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_PINS-1:0]          ext_pin_i,
  input  logic                       stop_mode_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [DATA_W-1:0]          bus_wdata_i,
  input  logic                       bus_we_i,
  output logic [DATA_W-1:0]          bus_rdata_o,
  output logic [N_LINES-1:0]         irq_o,
  output logic                       wake_o,
  output logic [LVL_BITS-1:0]        irq_level_o,
  output logic [eirq_pkg::VEC_W-1:0] vec_hi_addr_o,
  output logic [eirq_pkg::VEC_W-1:0] vec_lo_addr_o
);
  import eirq_pkg::*;

  logic [N_PINS-1:0]      pin_hit;
  logic [N_PINS-1:0]      pin_flag;
  logic [N_PINS-1:0]      pin_en;
  logic [N_PINS-1:0][1:0] pin_mode;
  logic [N_PINS-1:0]      armed;
  logic [N_LINES-1:0]     line_req;
  logic [N_LINES-1:0]     irq_q;
  logic                   wake_q;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    eirq_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (ext_pin_i[p]),
      .mode_i (edge_mode_e'(pin_mode[p])),
      .hit_o  (pin_hit[p])
    );
  end

  eirq_regs #(
    .N_PINS(N_PINS), .PINS_PER_LINE(PINS_PER_LINE), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .CTRL_BASE(CTRL_BASE), .LEVEL_ADDR(LEVEL_ADDR),
    .LEVEL_W(LEVEL_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .we_i    (bus_we_i),
    .hit_i   (pin_hit),
    .flag_o  (pin_flag),
    .en_o    (pin_en),
    .mode_o  (pin_mode),
    .level_o (irq_level_o),
    .rdata_o (bus_rdata_o)
  );

  assign armed = pin_flag & pin_en;

  always_comb
    for (int l = 0; l < N_LINES; l++)
      line_req[l] = |armed[l*PINS_PER_LINE +: PINS_PER_LINE];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= line_req;
      wake_q <= stop_mode_i & (|armed);
    end
  end

  // Lowest-numbered active line owns the vector outputs.
  always_comb begin
    vec_hi_addr_o = '0;
    vec_lo_addr_o = '0;
    for (int l = N_LINES - 1; l >= 0; l--)
      if (irq_q[l]) begin
        vec_hi_addr_o = vec_hi_addr(l);
        vec_lo_addr_o = vec_lo_addr(l);
      end
  end

  assign irq_o  = irq_q;
  assign wake_o = wake_q;

endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
  parameter int N_PINS        = 4,
  parameter int PINS_PER_LINE = 2,
  parameter int N_LINES       = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_we_i,
  input logic               stop_mode_i,
  input logic [N_LINES-1:0] irq_o,
  input logic               wake_o,
  input logic [15:0]        vec_hi_addr_o,
  input logic [N_PINS-1:0]  flag,
  input logic [N_PINS-1:0]  en
);

  // R1: outputs quiet in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && !wake_o))
    else $error("p_reset_quiet_r1");

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    // R4: an armed pin raises its line next cycle
    p_irq_follows_r4: assert property (@(posedge clk) disable iff (rst)
      (|(flag[l*PINS_PER_LINE +: PINS_PER_LINE] & en[l*PINS_PER_LINE +: PINS_PER_LINE]))
      |=> irq_o[l])
      else $error("p_irq_follows_r4");
    // R4: a raised line always had an armed pin behind it
    p_irq_cause_r4: assert property (@(posedge clk) disable iff (rst)
      irq_o[l] |->
      $past(|(flag[l*PINS_PER_LINE +: PINS_PER_LINE] & en[l*PINS_PER_LINE +: PINS_PER_LINE])))
      else $error("p_irq_cause_r4");
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_flag
    // R3: a flag only drops after a bus write
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(flag[p]) |-> $past(bus_we_i))
      else $error("p_flag_sticky_r3");
  end

  // R7: wake only follows stop mode
  p_wake_stop_r7: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(stop_mode_i))
    else $error("p_wake_stop_r7");

  // R10: line 0 owns the vector whenever it is active
  p_vec_line0_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o[0] |-> (vec_hi_addr_o == 16'hFFFA))
    else $error("p_vec_line0_r10");

endmodule

bind ext_irq_ctrl eirq_checker #(
  .N_PINS(N_PINS), .PINS_PER_LINE(PINS_PER_LINE), .N_LINES(N_LINES)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_we_i      (bus_we_i),
  .stop_mode_i   (stop_mode_i),
  .irq_o         (irq_o),
  .wake_o        (wake_o),
  .vec_hi_addr_o (vec_hi_addr_o),
  .flag          (pin_flag),
  .en            (pin_en)
);

// File: tb/tb_ext_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ext_irq_ctrl;

  localparam logic [15:0] C1 = 16'h0070;
  localparam logic [15:0] C2 = 16'h0071;
  localparam logic [15:0] LV = 16'h007B;

  localparam logic [3:0] K_IRQ = 4'd0, K_WAKE = 4'd1, K_RD = 4'd2,
                         K_VHI = 4'd3, K_VLO = 4'd4, K_LVL = 4'd5;

  typedef struct packed {
    logic [31:0] due;
    logic [3:0]  kind;
    logic [15:0] val;
    logic [7:0]  req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ext_pin = '0;
  logic        stop_mode = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic [7:0]  rdata;
  logic [1:0]  irq;
  logic        wake;
  logic [3:0]  lvl;
  logic [15:0] vhi, vlo;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ext_irq_ctrl dut (
    .clk(clk), .rst(rst), .ext_pin_i(ext_pin), .stop_mode_i(stop_mode),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we),
    .bus_rdata_o(rdata), .irq_o(irq), .wake_o(wake), .irq_level_o(lvl),
    .vec_hi_addr_o(vhi), .vec_lo_addr_o(vlo)
  );

  function automatic logic [15:0] observe(input logic [3:0] k);
    case (k)
      K_IRQ:   return {14'd0, irq};
      K_WAKE:  return {15'd0, wake};
      K_RD:    return {8'd0, rdata};
      K_VHI:   return vhi;
      K_VLO:   return vlo;
      default: return {12'd0, lvl};
    endcase
  endfunction

  // Monitor: compare every due item a little after the falling edge.
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0 && int'(sb[0].due) <= cyc) begin
      exp_t e;
      logic [15:0] got;
      e = sb.pop_front();
      got = observe(e.kind);
      n_chk++;
      if (got !== e.val) begin
        n_fail++;
        $display("FAIL R%0d kind %0d cycle %0d: got %h expected %h",
                 e.req, e.kind, cyc, got, e.val);
      end
    end
  end

  task automatic push(input int d, input logic [3:0] k, input logic [15:0] v, input int r);
    exp_t e;
    e.due = d; e.kind = k; e.val = v; e.req = 8'(r);
    sb.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp_v, input int r);
    addr = a;
    push(cyc + 1, K_RD, {8'd0, exp_v}, r);
    @(negedge clk);
  endtask

  task automatic pin(input int idx, input logic v);
    ext_pin[idx] = v;
    step(4);
  endtask

  task automatic now(input logic [3:0] k, input logic [15:0] v, input int r);
    push(cyc, k, v, r);
    step(1);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    // R1: reset state
    now(K_IRQ, 16'h0, 1);
    now(K_WAKE, 16'h0, 1);
    now(K_LVL, 16'h0, 1);
    now(K_VHI, 16'h0, 1);
    rd(C1, 8'h00, 1);
    rd(C2, 8'h00, 1);
    rd(LV, 8'h00, 1);

    // R2: mode 00 ignores both edges
    pin(0, 1'b1); pin(0, 1'b0);
    rd(C1, 8'h00, 2);

    // R2: rising mode
    wr(C1, 8'h01);
    pin(0, 1'b1);
    rd(C1, 8'h09, 2);
    wr(C1, 8'h01);           // R3: clear by writing 0
    rd(C1, 8'h01, 3);
    pin(0, 1'b0);
    rd(C1, 8'h01, 2);        // R2: falling edge ignored in rising mode

    // R2: falling mode on pin 1 (bits [7:4]), R8 layout
    wr(C1, 8'h21);
    pin(1, 1'b1);
    rd(C1, 8'h21, 2);
    pin(1, 1'b0);
    rd(C1, 8'hA1, 8);
    wr(C1, 8'h29);           // R3: writing 1 to pin 0 flag does not set it
    rd(C1, 8'h21, 3);

    // R2: both-edge mode on pin 2
    wr(C2, 8'h03);
    pin(2, 1'b1);
    rd(C2, 8'h0B, 2);
    wr(C2, 8'h03);
    rd(C2, 8'h03, 3);
    pin(2, 1'b0);
    rd(C2, 8'h0B, 2);

    // R4: flag without enable raises nothing
    now(K_IRQ, 16'h0, 4);
    // R5: enabling a flagged pin fires next cycle; R10 line 1 vector
    wr(C2, 8'h0F);
    push(cyc + 1, K_IRQ, 16'h2, 5);
    push(cyc + 1, K_VHI, 16'hFFF8, 10);
    push(cyc + 1, K_VLO, 16'hFFF9, 10);
    push(cyc + 1, K_WAKE, 16'h0, 7);
    step(1);

    // R7: wake in stop mode
    stop_mode = 1'b1;
    push(cyc + 1, K_WAKE, 16'h1, 7);
    step(1);
    wr(C2, 8'h07);
    push(cyc + 1, K_IRQ, 16'h0, 4);
    push(cyc + 1, K_WAKE, 16'h0, 7);
    push(cyc + 1, K_VHI, 16'h0, 10);
    step(1);

    // R6: enable plus clear in one write leaves nothing pending
    wr(C2, 8'h03);
    pin(2, 1'b1);
    rd(C2, 8'h0B, 2);
    wr(C2, 8'h07);
    push(cyc + 1, K_IRQ, 16'h0, 6);
    push(cyc + 1, K_WAKE, 16'h0, 6);
    step(1);
    rd(C2, 8'h07, 6);

    // R4 / R10: line 0 active
    wr(C1, 8'h05);
    pin(0, 1'b1);
    now(K_IRQ, 16'h1, 4);
    now(K_VHI, 16'hFFFA, 10);
    now(K_VLO, 16'hFFFB, 10);
    now(K_WAKE, 16'h1, 7);
    pin(0, 1'b0);
    wr(C1, 8'h05);
    push(cyc + 1, K_IRQ, 16'h0, 4);
    step(1);

    // R3: edge and clearing write in the same cycle, edge wins
    ext_pin[0] = 1'b1;
    step(2);
    wr(C1, 8'h05);
    rd(C1, 8'h0D, 3);
    now(K_IRQ, 16'h1, 3);

    // R10: both lines active, line 0 wins
    pin(2, 1'b0);
    now(K_IRQ, 16'h3, 4);
    now(K_VHI, 16'hFFFA, 10);
    wr(C1, 8'h05);
    wr(C2, 8'h07);
    push(cyc + 1, K_IRQ, 16'h0, 4);
    step(1);

    // R9: level byte
    wr(LV, 8'hFE);
    now(K_LVL, 16'hE, 9);
    rd(LV, 8'h0E, 9);

    // R8: unmapped write changes nothing
    wr(16'h0072, 8'hFF);
    rd(C1, 8'h05, 8);
    rd(C2, 8'h07, 8);
    now(K_IRQ, 16'h0, 8);

    step(3);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule